// File: doc/BRIEF.md
# PTP Frame Timestamp Capture Unit

This unit sits beside a MAC or PHY datapath and records the time at which selected PTP frames cross it. Two event ports carry the datapath's frame notifications, one for received frames and one for transmitted frames. Each notification has a strobe, the 4-bit PTP messageType and the 16-bit sequenceId. A 32-bit counter inside the unit advances once per clock. On an accepted event the counter value of that cycle is written, together with the sequenceId, into one of three single-entry slots.

The slots are numbered 0 and 1 for received frames and 2 for transmitted frames. A per-type enable mask decides which frames are stamped at all. A per-type steering mask decides which of the two receive slots a received stamp goes to. Each slot runs a two-state machine. In FREE it accepts a stamp on the CAPTURE transition and moves to HELD. In HELD it keeps its stamp: a further hit leaves it in HELD and sets a sticky overrun flag, and the RELEASE transition on a software pulse returns it to FREE.

Software writes the two masks and reads them back. It selects one slot with an index and reads that slot's valid bit, overrun flag, timestamp and sequenceId. It frees the slot with a release strobe and clears its overrun flag with a separate write-one-to-clear strobe.

Top module: `ptpcap_unit`

## Requirements
- R1: Reset empties all three slots, clears their overrun flags and zeroes their stored time and sequence. It loads the enable mask with 16'h0203 (types 0, 1 and 9) and the steering mask with 16'h0202 (types 1 and 9). It sets the time counter to 0.
- R2: `time_now` grows by exactly 1 each clock. A stamp equals the `time_now` value present in the cycle in which its strobe is high.
- R3: An event whose type bit is 0 in the enable mask changes no slot's valid bit, stored data or overrun flag.
- R4: An enabled receive event goes to slot 1 when its type bit is set in the steering mask, and to slot 0 when that bit is clear.
- R5: An enabled transmit event always goes to slot 2, whatever the steering mask holds. A receive event and a transmit event in the same cycle are both captured.
- R6: The sequenceId of the captured frame is stored with its timestamp and read back with it.
- R7: An enabled event that maps to a HELD slot is dropped. The slot keeps its time and sequenceId and sets its overrun flag, which stays set.
- R8: A `rel_stb` pulse moves the slot chosen by `sel_slot` from HELD to FREE, and that slot can capture an event in the very next cycle. An event that hits a HELD slot in the same cycle as its release is dropped and counted as an overrun.
- R9: An `ovr_clr_stb` pulse clears the overrun flag of the slot chosen by `sel_slot` and leaves its valid bit alone. If a new overrun happens in the same cycle, the flag stays set.
- R10: A write with `cfg_sel`=0 loads the enable mask and a write with `cfg_sel`=1 loads the steering mask. The new value is read back on the next cycle and applies to events from that cycle on.
- R11: `sel_slot` values 0 to 2 read the matching slot. The value 3 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | Received-frame event strobe |
| rx_type | input | 4 | messageType of the received frame |
| rx_seq | input | 16 | sequenceId of the received frame |
| tx_stb | input | 1 | Transmitted-frame event strobe |
| tx_type | input | 4 | messageType of the transmitted frame |
| tx_seq | input | 16 | sequenceId of the transmitted frame |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | Write target: 0 enable mask, 1 steering mask |
| cfg_wdata | input | 16 | Mask write value |
| en_mask | output | 16 | Current enable mask |
| steer_mask | output | 16 | Current steering mask |
| time_now | output | 32 | Free-running time counter |
| sel_slot | input | 2 | Slot index for read, release and overrun clear |
| rel_stb | input | 1 | Release strobe for the selected slot |
| ovr_clr_stb | input | 1 | Overrun clear strobe for the selected slot |
| sel_vld | output | 1 | Selected slot holds a stamp |
| sel_ovr | output | 1 | Selected slot's overrun flag |
| sel_ts | output | 32 | Selected slot's timestamp |
| sel_seq | output | 16 | Selected slot's sequenceId |

## Verification
The properties assume that `sel_slot` stays stable while a release or clear strobe is high. They also assume that strobes are plain one-cycle pulses, sampled together with the type field of the same cycle. The departure-slot properties assume that a release of a FREE slot never coincides with a capture into it, because that case is left undefined. The stimulus drives every event, release and clear in a single cycle at the falling edge and returns the strobes to zero at the next falling edge. It only releases slots that are HELD, so the undefined case never occurs.

// File: rtl/ptpcap_pkg.sv
package ptpcap_pkg;

    // number of capture slots and their fixed roles
    localparam int NSLOT    = 3;
    localparam int SLOT_RX0 = 0;
    localparam int SLOT_RX1 = 1;
    localparam int SLOT_TX  = 2;
    localparam int SEL_W    = $clog2(NSLOT + 1);

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/ptpcap_timebase.sv
module ptpcap_timebase #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

endmodule

// File: rtl/ptpcap_cfg.sv
module ptpcap_cfg #(
    parameter int          MASK_W     = 16,
    parameter logic [15:0] EN_RESET   = 16'h0203,
    parameter logic [15:0] STEER_RESET = 16'h0202
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [MASK_W-1:0] wdata,
    output logic [MASK_W-1:0] en_q,
    output logic [MASK_W-1:0] steer_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= MASK_W'(EN_RESET);
            steer_q <= MASK_W'(STEER_RESET);
        end else if (we) begin
            if (sel) steer_q <= wdata;
            else     en_q    <= wdata;
        end
    end

endmodule

// File: rtl/ptpcap_route.sv
module ptpcap_route
    import ptpcap_pkg::*;
#(
    parameter int TYPE_W = 4,
    localparam int MASK_W = 1 << TYPE_W
) (
    input  logic              rx_stb,
    input  logic [TYPE_W-1:0] rx_type,
    input  logic              tx_stb,
    input  logic [TYPE_W-1:0] tx_type,
    input  logic [MASK_W-1:0] en_mask,
    input  logic [MASK_W-1:0] steer_mask,
    output logic [NSLOT-1:0]  hit
);

    logic rx_take;
    logic tx_take;

    assign rx_take = rx_stb && en_mask[rx_type];
    assign tx_take = tx_stb && en_mask[tx_type];

    always_comb begin
        hit = '0;
        if (rx_take) begin
            if (steer_mask[rx_type]) hit[SLOT_RX1] = 1'b1;
            else                     hit[SLOT_RX0] = 1'b1;
        end
        hit[SLOT_TX] = tx_take;
    end

endmodule

// File: rtl/ptpcap_slot.sv
module ptpcap_slot
    import ptpcap_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [TS_W-1:0]  ts_in,
    input  logic [SEQ_W-1:0] seq_in,
    input  logic             rel,
    input  logic             clr,
    output logic             vld,
    output logic             ovr,
    output logic [TS_W-1:0]  ts,
    output logic [SEQ_W-1:0] seq
);

    slot_state_e state_q;
    slot_state_e state_d;
    logic        capture;
    logic        overrun;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // transitions: CAPTURE (FREE->HELD), RELEASE (HELD->FREE)
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        overrun = 1'b0;
        unique case (state_q)
            SLOT_FREE: begin
                if (hit) begin
                    state_d = SLOT_HELD;
                    capture = 1'b1;
                end
            end
            SLOT_HELD: begin
                overrun = hit;
                if (rel) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            ts  <= '0;
            seq <= '0;
        end else begin
            if (capture) begin
                ts  <= ts_in;
                seq <= seq_in;
            end
            if (overrun)  ovr <= 1'b1;
            else if (clr) ovr <= 1'b0;
        end
    end

    assign vld = (state_q == SLOT_HELD);

endmodule

// File: rtl/ptpcap_unit.sv
module ptpcap_unit
    import ptpcap_pkg::*;
#(
    parameter int          TS_W        = 32,
    parameter int          SEQ_W       = 16,
    parameter int          TYPE_W      = 4,
    parameter logic [15:0] EN_RESET    = 16'h0203,
    parameter logic [15:0] STEER_RESET = 16'h0202,
    localparam int         MASK_W      = 1 << TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_stb,
    input  logic [TYPE_W-1:0] rx_type,
    input  logic [SEQ_W-1:0]  rx_seq,
    input  logic              tx_stb,
    input  logic [TYPE_W-1:0] tx_type,
    input  logic [SEQ_W-1:0]  tx_seq,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [MASK_W-1:0] cfg_wdata,
    output logic [MASK_W-1:0] en_mask,
    output logic [MASK_W-1:0] steer_mask,
    output logic [TS_W-1:0]   time_now,
    input  logic [SEL_W-1:0]  sel_slot,
    input  logic              rel_stb,
    input  logic              ovr_clr_stb,
    output logic              sel_vld,
    output logic              sel_ovr,
    output logic [TS_W-1:0]   sel_ts,
    output logic [SEQ_W-1:0]  sel_seq
);

    logic [NSLOT-1:0]            slot_hit;
    logic [NSLOT-1:0]            slot_vld;
    logic [NSLOT-1:0]            slot_ovr;
    logic [NSLOT-1:0][TS_W-1:0]  slot_ts;
    logic [NSLOT-1:0][SEQ_W-1:0] slot_seq;

    ptpcap_timebase #(.TS_W(TS_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .count (time_now)
    );

    ptpcap_cfg #(
        .MASK_W      (MASK_W),
        .EN_RESET    (EN_RESET),
        .STEER_RESET (STEER_RESET)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .en_q    (en_mask),
        .steer_q (steer_mask)
    );

    ptpcap_route #(.TYPE_W(TYPE_W)) u_route (
        .rx_stb     (rx_stb),
        .rx_type    (rx_type),
        .tx_stb     (tx_stb),
        .tx_type    (tx_type),
        .en_mask    (en_mask),
        .steer_mask (steer_mask),
        .hit        (slot_hit)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic             pick;
        logic [SEQ_W-1:0] seq_src;

        assign pick    = (sel_slot == SEL_W'(k));
        assign seq_src = (k == SLOT_TX) ? tx_seq : rx_seq;

        ptpcap_slot #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (slot_hit[k]),
            .ts_in  (time_now),
            .seq_in (seq_src),
            .rel    (rel_stb && pick),
            .clr    (ovr_clr_stb && pick),
            .vld    (slot_vld[k]),
            .ovr    (slot_ovr[k]),
            .ts     (slot_ts[k]),
            .seq    (slot_seq[k])
        );
    end

    // read-side selection; indices past the last slot read zero
    always_comb begin
        sel_vld = 1'b0;
        sel_ovr = 1'b0;
        sel_ts  = '0;
        sel_seq = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (sel_slot == SEL_W'(k)) begin
                sel_vld = slot_vld[k];
                sel_ovr = slot_ovr[k];
                sel_ts  = slot_ts[k];
                sel_seq = slot_seq[k];
            end
        end
    end

endmodule

// File: rtl/ptpcap_chk.sv
module ptpcap_chk #(
    parameter int TS_W   = 32,
    parameter int TYPE_W = 4,
    parameter int SEL_W  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_stb,
    input logic [TYPE_W-1:0]      rx_type,
    input logic                   tx_stb,
    input logic [TYPE_W-1:0]      tx_type,
    input logic                   rel_stb,
    input logic                   ovr_clr_stb,
    input logic [SEL_W-1:0]       sel_slot,
    input logic [(1<<TYPE_W)-1:0] en_mask,
    input logic [TS_W-1:0]        time_now,
    input logic [2:0]             slot_vld,
    input logic [2:0]             slot_ovr,
    input logic [TS_W-1:0]        dep_ts
);

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_now == $past(time_now) + TS_W'(1));

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb && !en_mask[rx_type] && !tx_stb && !rel_stb && !ovr_clr_stb
        |=> $stable(slot_vld) && $stable(slot_ovr));

    // R5
    dep_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb && en_mask[tx_type] && !slot_vld[2]
        |=> slot_vld[2] && dep_ts == $past(time_now));

    // R7
    dep_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb && en_mask[tx_type] && slot_vld[2]
        |=> slot_ovr[2] && $stable(dep_ts));

    // R8
    dep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_stb && sel_slot == SEL_W'(2) |=> !slot_vld[2]);

    // R9
    clr_keeps_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr_stb && !rel_stb && !rx_stb && !tx_stb |=> $stable(slot_vld));

endmodule

bind ptpcap_unit ptpcap_chk #(
    .TS_W   (TS_W),
    .TYPE_W (TYPE_W),
    .SEL_W  (ptpcap_pkg::SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_stb      (rx_stb),
    .rx_type     (rx_type),
    .tx_stb      (tx_stb),
    .tx_type     (tx_type),
    .rel_stb     (rel_stb),
    .ovr_clr_stb (ovr_clr_stb),
    .sel_slot    (sel_slot),
    .en_mask     (en_mask),
    .time_now    (time_now),
    .slot_vld    (slot_vld),
    .slot_ovr    (slot_ovr),
    .dep_ts      (slot_ts[2])
);

// File: tb/sim_ptpcap_unit.sv
module sim_ptpcap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_stb = 1'b0, tx_stb = 1'b0;
    logic [3:0]  rx_type = '0, tx_type = '0;
    logic [15:0] rx_seq = '0, tx_seq = '0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] en_mask, steer_mask;
    logic [31:0] time_now;
    logic [1:0]  sel_slot = '0;
    logic        rel_stb = 1'b0, ovr_clr_stb = 1'b0;
    logic        sel_vld, sel_ovr;
    logic [31:0] sel_ts;
    logic [15:0] sel_seq;

    always #4 clk = ~clk;

    ptpcap_unit u0 (.*);

    typedef struct {
        int          slot;
        bit          vld;
        bit          ovr;
        logic [31:0] ts;
        logic [15:0] seq;
        string       req;
    } item_t;

    item_t       q[$];
    bit          mon_busy = 1'b0;
    int          nchk = 0, nfail = 0;

    // reference state, following the requirements
    bit          m_vld[3], m_ovr[3];
    logic [31:0] m_ts[3];
    logic [15:0] m_seq[3];
    logic [15:0] m_en = 16'h0203, m_st = 16'h0202;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with the read port
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                mon_busy = 1'b1;
                it = q.pop_front();
                sel_slot = it.slot[1:0];
                #1;
                chk(it.req, $sformatf("slot%0d vld", it.slot), 32'(sel_vld), 32'(it.vld));
                chk(it.req, $sformatf("slot%0d ovr", it.slot), 32'(sel_ovr), 32'(it.ovr));
                chk(it.req, $sformatf("slot%0d ts", it.slot), sel_ts, it.ts);
                chk(it.req, $sformatf("slot%0d seq", it.slot), 32'(sel_seq), 32'(it.seq));
            end
            mon_busy = 1'b0;
        end
    end

    task automatic post(string req);
        for (int k = 0; k < 3; k++) begin
            item_t it;
            it.slot = k; it.vld = m_vld[k]; it.ovr = m_ovr[k];
            it.ts = m_ts[k]; it.seq = m_seq[k]; it.req = req;
            q.push_back(it);
        end
        while (q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    // drives one cycle of stimulus now (at a falling edge), updates the model
    task automatic step(bit rxs, logic [3:0] rxt, logic [15:0] rxq,
                        bit txs, logic [3:0] txt, logic [15:0] txq,
                        bit rel, bit clr, logic [1:0] s);
        bit          hit[3];
        logic [31:0] t;
        rx_stb = rxs; rx_type = rxt; rx_seq = rxq;
        tx_stb = txs; tx_type = txt; tx_seq = txq;
        rel_stb = rel; ovr_clr_stb = clr; sel_slot = s;
        t = time_now;
        hit[0] = 0; hit[1] = 0; hit[2] = 0;
        if (rxs && m_en[rxt]) hit[m_st[rxt] ? 1 : 0] = 1;
        if (txs && m_en[txt]) hit[2] = 1;
        for (int k = 0; k < 3; k++) begin
            bit held;
            held = m_vld[k];
            if (hit[k] && !held) begin
                m_vld[k] = 1; m_ts[k] = t; m_seq[k] = (k == 2) ? txq : rxq;
            end
            if (hit[k] && held) m_ovr[k] = 1;
            else if (clr && s == 2'(k)) m_ovr[k] = 0;
            if (rel && s == 2'(k) && held) m_vld[k] = 0;
        end
        @(negedge clk);
        rx_stb = 0; tx_stb = 0; rel_stb = 0; ovr_clr_stb = 0;
    endtask

    task automatic cfg_write(bit which, logic [15:0] v);
        cfg_we = 1; cfg_sel = which; cfg_wdata = v;
        if (which) m_st = v; else m_en = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] t0;
        for (int k = 0; k < 3; k++) begin
            m_vld[k] = 0; m_ovr[k] = 0; m_ts[k] = '0; m_seq[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "time_now", time_now, 32'd0);
        chk("R1", "en_mask", 32'(en_mask), 32'h0203);
        chk("R1", "steer_mask", 32'(steer_mask), 32'h0202);
        rst_n = 1'b1;
        @(negedge clk);
        post("R1");

        // R2 counter rate
        t0 = time_now;
        repeat (5) @(negedge clk);
        chk("R2", "time_now", time_now, t0 + 32'd5);

        // R4 R6: Sync received -> slot 0
        step(1, 4'd0, 16'h1111, 0, 4'd0, 16'h0, 0, 0, 2'd0);
        post("R4");
        // R5: Delay_Req received -> slot 1, departure in same cycle -> slot 2
        step(1, 4'd1, 16'h2222, 1, 4'd0, 16'h3333, 0, 0, 2'd0);
        post("R5");
        // R7: second Sync into held slot 0
        step(1, 4'd0, 16'h4444, 0, 4'd0, 16'h0, 0, 0, 2'd0);
        post("R7");
        // R9: clear overrun of slot 0, valid stays
        step(0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 0, 1, 2'd0);
        post("R9");
        // R3: disabled types against held slots
        step(1, 4'd2, 16'h5555, 1, 4'd3, 16'h5656, 0, 0, 2'd0);
        post("R3");
        // R8: release slot 0 then capture on the next cycle
        step(0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 1, 0, 2'd0);
        step(1, 4'd0, 16'h6666, 0, 4'd0, 16'h0, 0, 0, 2'd0);
        post("R8");
        // R8: release and hit of held slot 2 in one cycle
        step(0, 4'd0, 16'h0, 1, 4'd0, 16'h7777, 1, 0, 2'd2);
        post("R8");
        // R9: overrun wins over clear in the same cycle
        step(1, 4'd0, 16'h8888, 0, 4'd0, 16'h0, 0, 1, 2'd0);
        post("R9");

        // R10: new steering and enable masks
        cfg_write(1, 16'h0001);
        chk("R10", "steer_mask", 32'(steer_mask), 32'h0001);
        step(0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 1, 0, 2'd1);
        step(1, 4'd0, 16'h9999, 0, 4'd0, 16'h0, 0, 0, 2'd0);
        post("R10");
        cfg_write(0, 16'h0004);
        chk("R10", "en_mask", 32'(en_mask), 32'h0004);
        step(0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 1, 0, 2'd2);
        step(0, 4'd0, 16'h0, 1, 4'd1, 16'haaaa, 0, 0, 2'd0);
        step(0, 4'd0, 16'h0, 1, 4'd2, 16'hbbbb, 0, 0, 2'd0);
        post("R10");

        // R11: index 3 reads zero
        sel_slot = 2'd3;
        #1;
        chk("R11", "vld", 32'(sel_vld), 32'd0);
        chk("R11", "ovr", 32'(sel_ovr), 32'd0);
        chk("R11", "ts", sel_ts, 32'd0);
        chk("R11", "seq", 32'(sel_seq), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule